// File: doc/BRIEF.md
# Two-Level Radix Page-Table Walker

On a translation miss this block resolves one 64-bit effective address to a 4 KiB physical page by walking a two-level radix tree held in memory. A root value supplies the base of the top-level table and its geometry. The block fetches one top-level directory entry, follows it to a second-level table, fetches the leaf entry there, and returns the physical address together with the leaf's twelve permission and attribute bits. If the walk fails, it raises a fault instead.

Table entries sit in memory with their eight bytes in reverse order. Every fetched doubleword is byte-swapped before it is read. The walk uses the size fields in the root value and in each directory entry. It checks them against the fixed geometry: 10 index bits at the top level, 9 at the second, and a 31-bit (2 GiB) address space. A mismatch is treated as a fault and not as an alternative layout.

Memory is reached through a plain request/acknowledge read port. The block holds the request and address until the acknowledge arrives, and read data is taken in the acknowledge cycle. Only one walk runs at a time.

Top module: `pgw_walker`

## Requirements
- R1: After reset, busy_o, done_o, fault_o and mem_req_o are all low.
- R2: A start accepted while idle, with a valid root and address, issues a first read at (root AND 0x00ffffffffffff00) + 8 × ea[30:21].
- R3: Each fetched doubleword is interpreted only after its bytes are reversed: memory byte 0 becomes bits [63:56] of the entry.
- R4: A directory entry (bit 63 = 1, bit 62 = 0, bits [4:0] = 9) leads to a second read at (entry AND 0x00ffffffffffff00) + 8 × ea[20:12].
- R5: A leaf (bit 63 = 1, bit 62 = 1) at the second level gives a one-cycle done_o with pa_o = {8'h00, entry[55:12], ea[11:0]} and perm_o = entry[11:0].
- R6: An entry with bit 63 clear at either level gives fault_o with pa_o and perm_o zero, and no further read is made.
- R7: A leaf found at the top level, or a directory found at the second level, gives fault_o.
- R8: A root whose bits [4:0] are not 10, or whose space field {bits 62:61, bits 7:5} is nonzero, faults with no memory read. A directory whose size bits [4:0] are not 9 faults after one read.
- R9: An effective address with any of bits [63:31] set faults with no memory read.
- R10: busy_o is high from the cycle after a start is accepted until the cycle in which done_o or fault_o is raised, and is low in that cycle. A start while busy is ignored.
- R11: mem_req_o, once raised, stays high with an unchanged mem_addr_o until mem_ack_i is seen.
- R12: done_o and fault_o are never high together, and done_o lasts exactly one cycle per walk.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a walk (taken only while idle) |
| ea_i | input | 64 | Effective address to translate |
| root_i | input | 64 | Root value: table base, top-level size, space field |
| busy_o | output | 1 | Walk in progress |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 64 | Doubleword address of the read |
| mem_ack_i | input | 1 | Read acknowledge; data valid in the same cycle |
| mem_rdata_i | input | 64 | Read data as stored (byte-reversed) |
| done_o | output | 1 | One-cycle pulse: translation found |
| fault_o | output | 1 | One-cycle pulse: translation failed |
| pa_o | output | 64 | Physical address (zero on fault) |
| perm_o | output | 12 | Leaf permission and attribute flags (zero on fault) |

## Verification
Walks cover addresses near the bottom and the top of the 2 GiB space, with small and wide physical page numbers. The same translations run again with memory latencies of zero and several cycles, which tells a correct request hold apart from a request dropped early. Failure cases cover each place a walk can stop: an empty top-level slot, an empty leaf slot, a leaf at the top level, a directory at the bottom level, a bad directory size, a bad root and an out-of-range address. For each, the number of reads issued shows at which level the decision was made. A second start sent in the middle of a walk must leave the result and the read trace unchanged.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
    localparam int unsigned WORD_W    = 64;
    localparam int unsigned PAGE_BITS = 12;
    localparam int unsigned SIZE_W    = 5;
    localparam int unsigned PPN_W     = 56 - PAGE_BITS;
    localparam logic [WORD_W-1:0] BASE_MASK = 64'h00ff_ffff_ffff_ff00;

    typedef enum logic [1:0] {
        W_IDLE = 2'd0,
        W_TOP  = 2'd1,
        W_LEAF = 2'd2
    } wstate_e;

    typedef struct packed {
        logic              valid;
        logic              leaf;
        logic [SIZE_W-1:0] size;
        logic [WORD_W-1:0] base;
        logic [PPN_W-1:0]  ppn;
        logic [PAGE_BITS-1:0] flags;
    } pte_t;
endpackage

// File: rtl/pgw_swap.sv
module pgw_swap #(
    parameter int unsigned BYTES = 8
) (
    input  logic [BYTES*8-1:0] raw_i,
    output logic [BYTES*8-1:0] nat_o
);
    for (genvar b = 0; b < BYTES; b++) begin : g_byte
        assign nat_o[b*8 +: 8] = raw_i[(BYTES-1-b)*8 +: 8];
    end
endmodule

// File: rtl/pgw_pte_dec.sv
module pgw_pte_dec
    import pgw_pkg::*;
(
    input  logic [WORD_W-1:0] ent_i,
    output pte_t              pte_o
);
    always_comb begin
        pte_o.valid = ent_i[63];
        pte_o.leaf  = ent_i[62];
        pte_o.size  = ent_i[SIZE_W-1:0];
        pte_o.base  = ent_i & BASE_MASK;
        pte_o.ppn   = ent_i[55:PAGE_BITS];
        pte_o.flags = ent_i[PAGE_BITS-1:0];
    end
endmodule

// File: rtl/pgw_root_dec.sv
module pgw_root_dec
    import pgw_pkg::*;
#(
    parameter int unsigned TOP_BITS = 10
) (
    input  logic [WORD_W-1:0] root_i,
    output logic [WORD_W-1:0] base_o,
    output logic              ok_o
);
    localparam logic [SIZE_W-1:0] TOP_SIZE = SIZE_W'(TOP_BITS);

    logic [4:0] space;

    always_comb begin
        space  = {root_i[62:61], root_i[7:5]};
        base_o = root_i & BASE_MASK;
        ok_o   = (root_i[SIZE_W-1:0] == TOP_SIZE) && (space == 5'd0);
    end
endmodule

// File: rtl/pgw_walker.sv
module pgw_walker
    import pgw_pkg::*;
#(
    parameter int unsigned TOP_BITS  = 10,
    parameter int unsigned LEAF_BITS = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [63:0]       ea_i,
    input  logic [63:0]       root_i,
    output logic              busy_o,
    output logic              mem_req_o,
    output logic [63:0]       mem_addr_o,
    input  logic              mem_ack_i,
    input  logic [63:0]       mem_rdata_i,
    output logic              done_o,
    output logic              fault_o,
    output logic [63:0]       pa_o,
    output logic [11:0]       perm_o
);
    localparam int unsigned LEAF_LSB   = PAGE_BITS;
    localparam int unsigned TOP_LSB    = PAGE_BITS + LEAF_BITS;
    localparam int unsigned SPACE_BITS = TOP_LSB + TOP_BITS;
    localparam int unsigned ENT_SHIFT  = 3;
    localparam logic [SIZE_W-1:0] LEAF_SIZE = SIZE_W'(LEAF_BITS);

    typedef struct packed {
        wstate_e              st;
        logic [WORD_W-1:0]    addr;
        logic [WORD_W-1:0]    ea;
        logic                 done;
        logic                 fault;
        logic [WORD_W-1:0]    pa;
        logic [PAGE_BITS-1:0] perm;
    } regs_t;

    regs_t q, d;

    logic [WORD_W-1:0] ent_nat;
    pte_t              pte;
    logic [WORD_W-1:0] root_base;
    logic              root_ok;
    logic              ea_ok;
    logic [TOP_BITS-1:0]  top_idx;
    logic [LEAF_BITS-1:0] leaf_idx;

    pgw_swap #(.BYTES(WORD_W / 8)) u_swap (
        .raw_i (mem_rdata_i),
        .nat_o (ent_nat)
    );

    pgw_pte_dec u_dec (
        .ent_i (ent_nat),
        .pte_o (pte)
    );

    pgw_root_dec #(.TOP_BITS(TOP_BITS)) u_root (
        .root_i (root_i),
        .base_o (root_base),
        .ok_o   (root_ok)
    );

    always_comb begin
        ea_ok    = (ea_i >> SPACE_BITS) == '0;
        top_idx  = ea_i[TOP_LSB +: TOP_BITS];
        leaf_idx = q.ea[LEAF_LSB +: LEAF_BITS];

        d       = q;
        d.done  = 1'b0;
        d.fault = 1'b0;

        unique case (q.st)
            W_IDLE: begin
                if (start_i) begin
                    d.ea   = ea_i;
                    d.pa   = '0;
                    d.perm = '0;
                    if (root_ok && ea_ok) begin
                        d.st   = W_TOP;
                        d.addr = root_base + (WORD_W'(top_idx) << ENT_SHIFT);
                    end else begin
                        d.fault = 1'b1;
                    end
                end
            end
            W_TOP: begin
                if (mem_ack_i) begin
                    if (pte.valid && !pte.leaf && pte.size == LEAF_SIZE) begin
                        d.st   = W_LEAF;
                        d.addr = pte.base + (WORD_W'(leaf_idx) << ENT_SHIFT);
                    end else begin
                        d.st    = W_IDLE;
                        d.fault = 1'b1;
                    end
                end
            end
            W_LEAF: begin
                if (mem_ack_i) begin
                    d.st = W_IDLE;
                    if (pte.valid && pte.leaf) begin
                        d.done = 1'b1;
                        d.pa   = {8'h00, pte.ppn, q.ea[PAGE_BITS-1:0]};
                        d.perm = pte.flags;
                    end else begin
                        d.fault = 1'b1;
                    end
                end
            end
            default: d.st = W_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: W_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign busy_o     = (q.st != W_IDLE);
    assign mem_req_o  = (q.st == W_TOP) || (q.st == W_LEAF);
    assign mem_addr_o = q.addr;
    assign done_o     = q.done;
    assign fault_o    = q.fault;
    assign pa_o       = q.pa;
    assign perm_o     = q.perm;

    a_r11_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));

    a_r12_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_o, fault_o}));

    a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r10_idle_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || fault_o) |-> !busy_o);

    a_r10_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

    a_r6_fault_clears: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> (pa_o == 64'd0 && perm_o == 12'd0));
endmodule

// File: tb/tb_pgw_walker.sv
module tb_pgw_walker;
    localparam logic [63:0] MASK = 64'h00ff_ffff_ffff_ff00;
    localparam logic [63:0] ROOT_BASE = 64'h1_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [63:0] ea_i = '0;
    logic [63:0] root_i = '0;
    logic        busy_o, mem_req_o, mem_ack_i, done_o, fault_o;
    logic [63:0] mem_addr_o, mem_rdata_i, pa_o;
    logic [11:0] perm_o;

    int total = 0;
    int bad = 0;
    int lat = 0;
    int wait_cnt = 0;
    int cyc = 0;
    logic [63:0] mem [logic [63:0]];
    logic [63:0] rdlog [$];
    logic [63:0] free_ptr = 64'h1_2000;
    logic [63:0] root_ok;

    always #2.5 clk = ~clk;

    pgw_walker dut (
        .clk, .rst_n, .start_i, .ea_i, .root_i, .busy_o,
        .mem_req_o, .mem_addr_o, .mem_ack_i, .mem_rdata_i,
        .done_o, .fault_o, .pa_o, .perm_o
    );

    function automatic logic [63:0] rev(input logic [63:0] v);
        logic [63:0] r;
        for (int b = 0; b < 8; b++) r[b*8 +: 8] = v[(7-b)*8 +: 8];
        return r;
    endfunction

    function automatic logic [63:0] fetch(input logic [63:0] a);
        return mem.exists(a) ? rev(mem[a]) : 64'd0;
    endfunction

    task automatic put(input logic [63:0] a, input logic [63:0] native);
        mem[a] = rev(native);
    endtask

    task automatic map(input logic [63:0] ea, input logic [63:0] pa, input logic [11:0] fl);
        logic [63:0] da;
        logic [63:0] de;
        da = ROOT_BASE + 64'(ea[30:21]) * 8;
        de = fetch(da);
        if (de == 0) begin
            de = 64'h8000_0000_0000_0000 | free_ptr | 64'd9;
            put(da, de);
            free_ptr = free_ptr + 64'h1000;
        end
        put((de & MASK) + 64'(ea[20:12]) * 8,
            64'hC000_0000_0000_0000 | (pa & 64'h00ff_ffff_ffff_f000) | 64'(fl));
    endtask

    // behavioural expectation of a walk
    task automatic model(input logic [63:0] ea, input logic [63:0] root,
                         output bit f, output logic [63:0] pa, output logic [11:0] pm,
                         output int n, output logic [63:0] a0, output logic [63:0] a1);
        logic [63:0] e;
        f = 1'b1; pa = '0; pm = '0; n = 0; a0 = '0; a1 = '0;
        if (ea[63:31] != 0 || root[4:0] != 5'd10 || root[62:61] != 0 || root[7:5] != 0) return;
        a0 = (root & MASK) + 64'(ea[30:21]) * 8;
        n = 1;
        e = fetch(a0);
        if (!e[63] || e[62] || e[4:0] != 5'd9) return;
        a1 = (e & MASK) + 64'(ea[20:12]) * 8;
        n = 2;
        e = fetch(a1);
        if (!e[63] || !e[62]) return;
        f = 1'b0;
        pa = {8'h00, e[55:12], ea[11:0]};
        pm = e[11:0];
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // memory responder
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack_i = 1'b0;
            mem_rdata_i = '0;
            wait_cnt = 0;
        end else if (mem_ack_i) begin
            mem_ack_i = 1'b0;
            wait_cnt = 0;
        end else if (mem_req_o) begin
            if (wait_cnt >= lat) begin
                mem_ack_i = 1'b1;
                mem_rdata_i = mem.exists(mem_addr_o) ? mem[mem_addr_o] : 64'd0;
                rdlog.push_back(mem_addr_o);
            end else begin
                wait_cnt++;
            end
        end else begin
            wait_cnt = 0;
        end
    end

    task automatic run(input logic [63:0] ea, input logic [63:0] root, input int l,
                       input bit poke, input string req);
        bit f; logic [63:0] pa; logic [11:0] pm; int n; logic [63:0] a0, a1;
        bit seen;
        model(ea, root, f, pa, pm, n, a0, a1);
        lat = l;
        rdlog.delete();
        @(negedge clk);
        ea_i = ea; root_i = root; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        seen = 1'b0;
        for (int k = 0; k < 80; k++) begin
            if (done_o || fault_o) begin seen = 1'b1; break; end
            // R10: busy on every cycle before the outcome
            check(busy_o === 1'b1, "R10", "busy during walk", 64'(busy_o), 64'd1);
            if (poke && k == 0) begin
                ea_i = 64'h7000; start_i = 1'b1;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
        end
        start_i = 1'b0;
        check(seen, req, "walk finished", 64'(seen), 64'd1);
        check(fault_o === f, req, "fault flag", 64'(fault_o), 64'(f));
        check(done_o === !f, req, "done flag", 64'(done_o), 64'(!f));
        check(pa_o === pa, req, "physical address", pa_o, pa);
        check(perm_o === pm, req, "flags", 64'(perm_o), 64'(pm));
        check(busy_o === 1'b0, "R10", "idle at outcome", 64'(busy_o), 64'd0);
        check(rdlog.size() == n, req, "read count", 64'(rdlog.size()), 64'(n));
        if (n >= 1 && rdlog.size() >= 1)
            check(rdlog[0] === a0, "R2", "top-level read address", rdlog[0], a0);
        if (n >= 2 && rdlog.size() >= 2)
            check(rdlog[1] === a1, "R4", "second-level read address", rdlog[1], a1);
        @(negedge clk);
        check(done_o === 1'b0 && fault_o === 1'b0, "R12", "outcome is one cycle",
              64'({done_o, fault_o}), 64'd0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++; total++;
            $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] d2000;
        root_ok = ROOT_BASE | 64'd10;
        map(64'h2000, 64'h2000, 12'h185);
        map(64'h7000, 64'h7000, 12'h186);
        map(64'h7FFF_F123, 64'h00AB_CDEF_0123_4000, 12'h1A5);
        // R7: leaf at top level (index 512)
        put(ROOT_BASE + 64'd512 * 8, 64'hC000_0000_0005_0000 | 64'h186);
        // R7: directory at second level (ea 0x5000)
        d2000 = fetch(ROOT_BASE) & MASK;
        put(d2000 + 64'd5 * 8, 64'h8000_0000_0003_0000 | 64'd9);
        // R8: directory with wrong size (index 256)
        put(ROOT_BASE + 64'd256 * 8, 64'h8000_0000_0004_0000 | 64'd8);

        repeat (3) @(negedge clk);
        // R1: reset state
        check(busy_o === 0 && done_o === 0 && fault_o === 0 && mem_req_o === 0, "R1",
              "outputs in reset", 64'({busy_o, done_o, fault_o, mem_req_o}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy_o === 0 && mem_req_o === 0, "R1", "idle after reset",
              64'({busy_o, mem_req_o}), 64'd0);

        // R2 R3 R4 R5: successful walks, several latencies
        run(64'h2000, root_ok, 0, 1'b0, "R5");
        run(64'h7ABC, root_ok, 2, 1'b0, "R5");
        run(64'h7FFF_F123, root_ok, 4, 1'b0, "R3");
        run(64'h2FFF, root_ok, 1, 1'b0, "R5");
        // R6: empty slots
        run(64'h1000_0000, root_ok, 1, 1'b0, "R6");
        run(64'h3000, root_ok, 3, 1'b0, "R6");
        // R7: wrong entry kinds
        run(64'h4000_0000, root_ok, 0, 1'b0, "R7");
        run(64'h5000, root_ok, 2, 1'b0, "R7");
        // R8: geometry checks
        run(64'h2000_0000, root_ok, 1, 1'b0, "R8");
        run(64'h2000, ROOT_BASE | 64'd9, 0, 1'b0, "R8");
        run(64'h2000, root_ok | 64'h20, 0, 1'b0, "R8");
        run(64'h2000, root_ok | 64'h2000_0000_0000_0000, 0, 1'b0, "R8");
        // R9: address out of range
        run(64'h8000_2000, root_ok, 0, 1'b0, "R9");
        run(64'hFFFF_FFFF_FFFF_F000, root_ok, 0, 1'b0, "R9");
        // R10: start during a walk is ignored (R11 via latency)
        run(64'h2000, root_ok, 5, 1'b1, "R10");
        run(64'h1000_0000, root_ok, 3, 1'b1, "R10");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule